// File: doc/BRIEF.md
# Daisy-Chained Interrupt Acknowledge Chain

A row of N interrupt cells shares one active-low request line towards a processor. Each cell holds a pending flag. The flag is set from the device's own request input on a rising clock edge. The request line goes low while any cell has its flag set.

When the processor raises the acknowledge input, a priority token enters cell 0 and ripples down the row through combinational logic. A cell with nothing pending passes the token on. The first pending cell keeps the token and places its vector on the shared data bus in the same cycle. Position fixes priority: cell 0 is highest and cell N-1 is lowest.

The shared bus is a multiplexer selected by a one-hot grant. It reads zero when no cell owns it. At the clock edge that ends an acknowledge cycle, the winning cell drops its pending flag. The next requester is then served in a later acknowledge cycle. Cell i has the vector VEC_BASE + i*VEC_STEP, which is 0x20, 0x28 and 0x30 with the default parameters.

Top module: `irq_chain`

## Requirements
- R1: While reset is low, all pending flags are held clear, even with requests present. Out of reset, `int_n` is 1 and `grant`, `prio_out` and `data_bus` are all zero.
- R2: A 1 on `dev_req[i]` at a rising edge sets cell i's pending flag. `int_n` reads 0 from that edge onward.
- R3: `int_n` is 1 exactly when no cell is pending, and no grant is given while it is 1.
- R4: With `inta` low, `grant`, `prio_out` and `data_bus` are all zero, whatever is pending.
- R5: With `inta` high, cell 0 receives the token. A cell that receives the token and has nothing pending sets its `prio_out` bit to 1.
- R6: A cell that does not receive the token drives its `prio_out` bit to 0, so every cell below the winner reads 0.
- R7: With `inta` high and at least one cell pending, the lowest-index pending cell is the only `grant` bit set, in the same cycle. `data_bus` then equals VEC_BASE + index*VEC_STEP.
- R8: At the rising edge that ends a cycle with `inta` high, the winner's pending flag is cleared and the other cells' flags are kept.
- R9: If `dev_req` of the winning cell is 1 at that same edge, its pending flag stays set.
- R10: With `inta` high and no cell pending, every `prio_out` bit is 1 and `data_bus` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dev_req | input | N | Per-device request, sampled each rising edge |
| inta | input | 1 | Acknowledge from the processor, enters cell 0 |
| int_n | output | 1 | Shared request line, active low |
| grant | output | N | One-hot marker of the cell that kept the token |
| prio_out | output | N | Token output of each cell |
| data_bus | output | VW | Vector of the winning cell, zero otherwise |

## Verification
`grant`, `prio_out` and `data_bus` follow `inta` and the pending flags with no register in between, so each is due in the same cycle as the acknowledge. `int_n`, and the effect of a clear, appear only in the cycle after the rising edge that samples the request or ends the acknowledge. The bench changes inputs on the falling edge and compares all outputs 1 ns later. Its reference copy of the pending flags advances once per rising edge, so each expectation describes the state after exactly the edges that have passed.

// File: rtl/irq_chain.sv
module irq_chain #(
  parameter int N = 3,
  parameter int VW = 8,
  parameter logic [VW-1:0] VEC_BASE = 8'h20,
  parameter logic [VW-1:0] VEC_STEP = 8'h08
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  dev_req,
  input  logic          inta,
  output logic          int_n,
  output logic [N-1:0]  grant,
  output logic [N-1:0]  prio_out,
  output logic [VW-1:0] data_bus
);

  logic [N-1:0] pend;
  logic [N-1:0] tok_in;
  logic [VW-1:0] vec_sel [N];

  assign int_n = ~|pend;

  for (genvar i = 0; i < N; i++) begin : g_cell
    localparam logic [VW-1:0] VEC = VW'(VEC_BASE + VW'(i) * VEC_STEP);

    if (i == 0) begin : g_head
      assign tok_in[i] = inta;
    end else begin : g_link
      assign tok_in[i] = prio_out[i-1];
    end

    assign prio_out[i] = tok_in[i] & ~pend[i];
    assign grant[i]    = tok_in[i] & pend[i];
    assign vec_sel[i]  = grant[i] ? VEC : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend[i] <= 1'b0;
      else        pend[i] <= (pend[i] & ~grant[i]) | dev_req[i];
    end
  end

  always_comb begin
    data_bus = '0;
    for (int k = 0; k < N; k++) data_bus = data_bus | vec_sel[k];
  end

endmodule

// File: rtl/irq_chain_chk.sv
module irq_chain_chk #(
  parameter int N = 3,
  parameter int VW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  dev_req,
  input logic          inta,
  input logic          int_n,
  input logic [N-1:0]  grant,
  input logic [N-1:0]  prio_out,
  input logic [VW-1:0] data_bus
);

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inta |-> (grant == '0 && prio_out == '0 && data_bus == '0));

  // R7
  single_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R3
  no_pend_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_n |-> grant == '0);

  // R7
  ack_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !int_n) |-> grant != '0);

  // R8
  cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && grant != '0 && (grant & dev_req) == '0) |=> ((grant & $past(grant)) == '0));

  // R6
  blocked_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> !prio_out[N-1]);

endmodule

bind irq_chain irq_chain_chk #(.N(N), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .inta(inta),
  .int_n(int_n), .grant(grant), .prio_out(prio_out), .data_bus(data_bus)
);

// File: tb/irq_chain_tb.sv
`timescale 1ns/1ps
module irq_chain_tb;
  localparam int N = 3;
  localparam int VW = 8;
  localparam logic [VW-1:0] VB = 8'h20;
  localparam logic [VW-1:0] VS = 8'h08;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] dev_req = '0;
  logic inta = 1'b0;
  logic int_n;
  logic [N-1:0] grant, prio_out;
  logic [VW-1:0] data_bus;

  always #2.5 clk = ~clk;

  irq_chain #(.N(N), .VW(VW), .VEC_BASE(VB), .VEC_STEP(VS)) u_dut (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .inta(inta),
    .int_n(int_n), .grant(grant), .prio_out(prio_out), .data_bus(data_bus)
  );

  typedef struct {
    string tag;
    logic int_n;
    logic [N-1:0] grant;
    logic [N-1:0] prio_out;
    logic [VW-1:0] bus;
  } exp_t;

  exp_t q[$];
  logic [N-1:0] mdl = '0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic exp_t predict(logic [N-1:0] p, logic ack, string tag);
    exp_t e;
    logic tok;
    e.tag = tag;
    e.int_n = ~|p;
    e.grant = '0;
    e.prio_out = '0;
    e.bus = '0;
    tok = ack;
    for (int i = 0; i < N; i++) begin
      if (tok && p[i]) begin
        e.grant[i] = 1'b1;
        e.bus = VW'(VB + VW'(i) * VS);
      end
      e.prio_out[i] = tok & ~p[i];
      tok = e.prio_out[i];
    end
    return e;
  endfunction

  task automatic cyc(input logic [N-1:0] req, input logic ack, input string tag);
    exp_t e;
    @(negedge clk);
    dev_req = req;
    inta = ack;
    e = predict(mdl, ack, tag);
    q.push_back(e);
    mdl = (mdl & ~e.grant) | req;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (int_n !== e.int_n || grant !== e.grant || prio_out !== e.prio_out || data_bus !== e.bus) begin
          errors++;
          $display("FAIL %s: int_n=%b grant=%b prio_out=%b bus=%h expected int_n=%b grant=%b prio_out=%b bus=%h",
                   e.tag, int_n, grant, prio_out, data_bus, e.int_n, e.grant, e.prio_out, e.bus);
        end
      end
    end
  end

  initial begin
    dev_req = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    q.push_back(predict('0, 1'b0, "R1 requests ignored in reset"));
    @(negedge clk);
    dev_req = '0;
    rst_n = 1'b1;
    mdl = '0;
    cyc(3'b000, 0, "R1 idle after reset");
    cyc(3'b010, 0, "R2 request not yet visible");
    cyc(3'b000, 0, "R2 R4 pending, no acknowledge");
    cyc(3'b000, 1, "R7 single requester wins");
    cyc(3'b000, 0, "R8 R3 line released after service");
    cyc(3'b111, 0, "R2 three requests");
    cyc(3'b000, 1, "R6 R7 head cell wins");
    cyc(3'b000, 1, "R5 R7 middle cell wins");
    cyc(3'b000, 1, "R5 R7 tail cell wins");
    cyc(3'b000, 1, "R10 token passes all cells");
    cyc(3'b000, 0, "R3 all served");
    cyc(3'b100, 0, "R2 tail request");
    cyc(3'b100, 1, "R9 request held at service edge");
    cyc(3'b000, 0, "R9 still pending");
    cyc(3'b000, 1, "R9 served again");
    cyc(3'b000, 0, "R3 released");
    cyc(3'b101, 0, "R2 two requests");
    cyc(3'b000, 0, "R4 quiet bus with pending");
    cyc(3'b000, 1, "R7 head before tail");
    cyc(3'b000, 1, "R5 tail after head cleared");
    cyc(3'b110, 0, "R2 middle and tail");
    cyc(3'b000, 1, "R7 middle wins");
    cyc(3'b000, 0, "R8 tail kept pending");
    cyc(3'b000, 1, "R8 tail served");
    cyc(3'b000, 0, "R3 final idle");
    @(negedge clk);
    #2;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule